// File: doc/BRIEF.md
# Core Module System Control Register Block

This block is the control and status register file for a processor core module. It sits on a simple register bus. The bus carries a word index, a read strobe and a write strobe. The word index is the byte offset divided by four. The block returns fixed identification and status words and holds the main and auxiliary oscillator settings behind a 16-bit unlock key. It also holds a control word whose bits drive the memory remap and an indicator LED, and a write to that word can request a system reset.

Two set/clear flag registers hold scratch state for software. A free-running reference counter advances on each reference tick. A small interrupt section combines a software-raised interrupt with separate IRQ and FIQ enables and drives one interrupt line. A read-only window returns a byte-per-word memory descriptor.

A read returns its data, and raises an error flag when the index is not implemented, one clock after the read strobe. Writes take effect at the clock edge that samples the strobe.

Top module: `cm_sysctl`

## Requirements
- R1: A read of index 0 returns 0x411A3001, a read of index 1 returns 0, and a read of index 4 returns 0x00100000.
- R2: A write to index 5 stores the low 16 bits of the data as the lock value. While the lock value equals 0xA05F, a read of index 5 returns 0x0001A05F. Otherwise it returns the stored lock value.
- R3: A write to index 2 (main oscillator) or index 7 (auxiliary oscillator) changes the register only while the lock value equals 0xA05F. Otherwise the register keeps its value.
- R4: A write to index 3 stores data bit 0 into the `led` output and data bit 2 into the `remap` output. All other control bits read as zero, bit 3 included. No other access changes `led` or `remap`.
- R5: A write to index 3 with data bit 3 set drives `reset_req` high for exactly one clock cycle, in the cycle after the write. `reset_req` is low at all other times.
- R6: A write to index 12 ORs the data into the first flag register, and a write to index 13 clears the bits that are set in the data. Index 12 reads this register. Indices 14 (set and read) and 15 (clear) do the same for a second, independent flag register.
- R7: The 32-bit counter at index 10 increases by one for each cycle with `ref_tick` high. Reset clears it, and writes do not affect it.
- R8: A write to index 20 with bit 0 set raises the soft interrupt, and a write to index 21 with bit 0 set drops it. The raw level (soft interrupt in bit 0) reads at indices 17 and 25, and bit 0 of the raw level reads at index 20. IRQ enable bits are set at index 18 (also read there) and cleared at index 19. FIQ enable bits are set at index 26 (also read there) and cleared at index 27. Index 16 returns raw AND IRQ enable, and index 24 returns raw AND FIQ enable. `int_req` is high while raw AND (IRQ enable OR FIQ enable) is non-zero.
- R9: After reset the main oscillator reads 0x01000048 and the auxiliary oscillator reads 0x0007FEFF. The init register reads 0x00000112. The SDRAM register reads 0x00011122 ORed with a size code taken from MEM_MB: 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 otherwise. The lock, control, flag, enable and soft interrupt state is zero after reset.
- R10: Indices 64 to 95 return one descriptor byte each, zero-extended. The bytes at indices 73 to 83 spell the ASCII text "SDRAM-MODEL" and all other bytes are zero. Indices 96 to 127 read zero.
- R11: A read of any index not named in R1 to R10 or R12 returns zero and sets `rd_err` for exactly the one cycle in which that data is presented. A write to such an index changes no state. A read of an implemented index leaves `rd_err` low.
- R12: The SDRAM register (index 8) and the init register (index 9) store any written value and read it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | AW (8) | Register word index |
| wdata | input | DW (32) | Write data |
| ref_tick | input | 1 | Reference clock enable; the counter advances once per high cycle |
| rdata | output | DW (32) | Read data, valid the cycle after `rd_en` |
| rd_err | output | 1 | Unimplemented index read, aligned with `rdata` |
| remap | output | 1 | Memory remap enable; low keeps boot flash at address zero |
| led | output | 1 | Indicator LED |
| reset_req | output | 1 | One-cycle system reset request |
| int_req | output | 1 | Core module interrupt line |

## Verification
The hardest case to reach is a pair of writes to the same oscillator register, one rejected and one accepted. The only difference between them is the lock value left by an earlier write to a different index. The stimulus table writes the oscillator while locked, unlocks with a key that has unrelated upper bits, writes again, and then relocks with a different value. Each write is followed by a read-back, so a key compare that looks at the wrong width or ignores the lock shows up as a wrong word. The interrupt line is handled the same way. Its enables and the soft interrupt are set and cleared in an order where the IRQ path and the FIQ path each hold the line on their own.

// File: rtl/cm_sysctl_pkg.sv
// Package: shared constants, register word indices and helper functions
// for the core module system control block. Assumes a 32-bit data word.
package cm_sysctl_pkg;

    localparam int REG_W  = 32;
    localparam int KEY_W  = 16;

    // word indices (byte offset divided by four)
    localparam int IX_ID        = 0;
    localparam int IX_ZERO      = 1;
    localparam int IX_OSC       = 2;
    localparam int IX_CTRL      = 3;
    localparam int IX_STAT      = 4;
    localparam int IX_LOCK      = 5;
    localparam int IX_AUX       = 7;
    localparam int IX_SDRAM     = 8;
    localparam int IX_INIT      = 9;
    localparam int IX_CNT       = 10;
    localparam int IX_FLAG_BASE = 12;
    localparam int IX_IRQ_STAT  = 16;
    localparam int IX_RAW       = 17;
    localparam int IX_IRQ_SET   = 18;
    localparam int IX_IRQ_CLR   = 19;
    localparam int IX_SOFT_SET  = 20;
    localparam int IX_SOFT_CLR  = 21;
    localparam int IX_FIQ_STAT  = 24;
    localparam int IX_FIQ_RAW   = 25;
    localparam int IX_FIQ_SET   = 26;
    localparam int IX_FIQ_CLR   = 27;
    localparam int IX_DESC_LO   = 64;
    localparam int IX_DESC_MID  = 96;
    localparam int IX_DESC_HI   = 128;

    localparam int NUM_FLAG_REGS = 2;

    // control bit positions
    localparam int CTRL_LED_BIT   = 0;
    localparam int CTRL_REMAP_BIT = 2;
    localparam int CTRL_RESET_BIT = 3;

    // fixed words and reset values
    localparam logic [REG_W-1:0] ID_WORD   = 32'h411A_3001;
    localparam logic [REG_W-1:0] STAT_WORD = 32'h0010_0000;
    localparam logic [REG_W-1:0] OSC_RST   = 32'h0100_0048;
    localparam logic [REG_W-1:0] AUX_RST   = 32'h0007_FEFF;
    localparam logic [REG_W-1:0] SDRAM_RST = 32'h0001_1122;
    localparam logic [REG_W-1:0] INIT_RST  = 32'h0000_0112;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;

    // descriptor text placed in the window
    localparam int TAG_LEN  = 11;
    localparam int TAG_BASE = 73;
    localparam logic [8*TAG_LEN-1:0] DESC_TAG = "SDRAM-MODEL";

    // Size code ORed into the SDRAM reset value, from the memory size in MB.
    function automatic logic [REG_W-1:0] sdram_size_code(input int mem_mb);
        if (mem_mb >= 256)      return 32'h10;
        else if (mem_mb >= 128) return 32'h0C;
        else if (mem_mb >= 64)  return 32'h08;
        else if (mem_mb >= 32)  return 32'h04;
        else                    return 32'h00;
    endfunction

    // Descriptor byte for a table index; zero outside the text field.
    function automatic logic [7:0] desc_byte(input int idx);
        int k;
        k = idx - TAG_BASE;
        if (k >= 0 && k < TAG_LEN)
            return DESC_TAG[8*(TAG_LEN-1-k) +: 8];
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/cm_key_osc.sv
// Lock key register and the two key-guarded oscillator registers.
// Assumes single-cycle write strobes that are already decoded by the parent.
module cm_key_osc
    import cm_sysctl_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int KW = KEY_W,
    parameter logic [DW-1:0] OSC_INIT = OSC_RST,
    parameter logic [DW-1:0] AUX_INIT = AUX_RST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lock,
    input  logic          wr_osc,
    input  logic          wr_aux,
    input  logic [DW-1:0] wdata,
    output logic [KW-1:0] lock_q,
    output logic [DW-1:0] lock_rd,
    output logic [DW-1:0] osc_q,
    output logic [DW-1:0] aux_q
);

    logic unlocked;

    // Key compare shared by the read view and the write gate.
    assign unlocked = (lock_q == KW'(UNLOCK_KEY));

    // Read view: status bit just above the key field while unlocked.
    assign lock_rd = unlocked ? (DW'(lock_q) | (DW'(1) << KW)) : DW'(lock_q);

    // Lock value takes the low key bits of any write.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= '0;
        else if (wr_lock) lock_q <= wdata[KW-1:0];
    end

    // Oscillator registers accept writes only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_q <= OSC_INIT;
            aux_q <= AUX_INIT;
        end else begin
            if (wr_osc && unlocked) osc_q <= wdata;
            if (wr_aux && unlocked) aux_q <= wdata;
        end
    end

endmodule

// File: rtl/cm_setclr_reg.sv
// Register with separate set and clear write ports; data bits select
// which bits change. Clears to zero on reset.
module cm_setclr_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_set,
    input  logic          wr_clr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    // OR in on set, mask out on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (wr_set) q <= q | wdata;
        else if (wr_clr) q <= q & ~wdata;
    end

endmodule

// File: rtl/cm_ref_counter.sv
// Free-running reference counter, advanced by a tick enable, cleared by
// reset, wraps at its width.
module cm_ref_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] count
);

    // Count reference ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + CW'(1);
    end

endmodule

// File: rtl/cm_int_ctrl.sv
// Interrupt section: software interrupt level in bit 0 of the raw vector,
// IRQ and FIQ enable masks with set/clear ports, and one combined line.
module cm_int_ctrl #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_irq_set,
    input  logic          wr_irq_clr,
    input  logic          wr_fiq_set,
    input  logic          wr_fiq_clr,
    input  logic          wr_soft_set,
    input  logic          wr_soft_clr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] raw,
    output logic [DW-1:0] irq_en,
    output logic [DW-1:0] fiq_en,
    output logic          int_req
);

    logic soft_q;

    // Soft interrupt level, changed only when data bit 0 is set.
    always_ff @(posedge clk) begin
        if (!rst_n)                       soft_q <= 1'b0;
        else if (wr_soft_set && wdata[0]) soft_q <= 1'b1;
        else if (wr_soft_clr && wdata[0]) soft_q <= 1'b0;
    end

    // IRQ enable mask.
    cm_setclr_reg #(.DW(DW)) u_irq_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_set (wr_irq_set),
        .wr_clr (wr_irq_clr),
        .wdata  (wdata),
        .q      (irq_en)
    );

    // FIQ enable mask.
    cm_setclr_reg #(.DW(DW)) u_fiq_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_set (wr_fiq_set),
        .wr_clr (wr_fiq_clr),
        .wdata  (wdata),
        .q      (fiq_en)
    );

    assign raw     = {{(DW-1){1'b0}}, soft_q};
    assign int_req = |(raw & (irq_en | fiq_en));

endmodule

// File: rtl/cm_sysctl.sv
// Core module system control registers. Word-indexed bus: writes act at the
// edge that samples wr_en; read data and error flag are registered and
// valid one cycle after rd_en. Assumes rd_en and wr_en are not both high.
module cm_sysctl
    import cm_sysctl_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = REG_W,
    parameter int CNT_W  = 32,
    parameter int MEM_MB = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          ref_tick,
    output logic [DW-1:0] rdata,
    output logic          rd_err,
    output logic          remap,
    output logic          led,
    output logic          reset_req,
    output logic          int_req
);

    localparam logic [DW-1:0] SDRAM_INIT = SDRAM_RST | sdram_size_code(MEM_MB);
    localparam logic [DW-1:0] CTRL_KEEP  =
        (DW'(1) << CTRL_LED_BIT) | (DW'(1) << CTRL_REMAP_BIT);

    // write strobes for the fixed registers
    logic wr_osc, wr_ctrl, wr_lock, wr_aux, wr_sdram, wr_init;
    logic wr_irq_set, wr_irq_clr, wr_fiq_set, wr_fiq_clr;
    logic wr_soft_set, wr_soft_clr;

    assign wr_osc      = wr_en && (addr == AW'(IX_OSC));
    assign wr_ctrl     = wr_en && (addr == AW'(IX_CTRL));
    assign wr_lock     = wr_en && (addr == AW'(IX_LOCK));
    assign wr_aux      = wr_en && (addr == AW'(IX_AUX));
    assign wr_sdram    = wr_en && (addr == AW'(IX_SDRAM));
    assign wr_init     = wr_en && (addr == AW'(IX_INIT));
    assign wr_irq_set  = wr_en && (addr == AW'(IX_IRQ_SET));
    assign wr_irq_clr  = wr_en && (addr == AW'(IX_IRQ_CLR));
    assign wr_fiq_set  = wr_en && (addr == AW'(IX_FIQ_SET));
    assign wr_fiq_clr  = wr_en && (addr == AW'(IX_FIQ_CLR));
    assign wr_soft_set = wr_en && (addr == AW'(IX_SOFT_SET));
    assign wr_soft_clr = wr_en && (addr == AW'(IX_SOFT_CLR));

    // state
    logic [KEY_W-1:0] lock_q;
    logic [DW-1:0]    lock_rd, osc_q, aux_q;
    logic [DW-1:0]    ctrl_q, sdram_q, init_q;
    logic             reset_req_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    raw_lvl, irq_en_q, fiq_en_q;
    logic [DW-1:0]    flag_q [NUM_FLAG_REGS];

    cm_key_osc #(
        .DW       (DW),
        .KW       (KEY_W),
        .OSC_INIT (OSC_RST),
        .AUX_INIT (AUX_RST)
    ) u_keyosc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lock (wr_lock),
        .wr_osc  (wr_osc),
        .wr_aux  (wr_aux),
        .wdata   (wdata),
        .lock_q  (lock_q),
        .lock_rd (lock_rd),
        .osc_q   (osc_q),
        .aux_q   (aux_q)
    );

    // One set/clear register per flag pair: set and read at even index, clear at odd.
    for (genvar g = 0; g < NUM_FLAG_REGS; g++) begin : g_flag
        logic wr_set_g, wr_clr_g;
        assign wr_set_g = wr_en && (addr == AW'(IX_FLAG_BASE + 2*g));
        assign wr_clr_g = wr_en && (addr == AW'(IX_FLAG_BASE + 2*g + 1));
        cm_setclr_reg #(.DW(DW)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_set (wr_set_g),
            .wr_clr (wr_clr_g),
            .wdata  (wdata),
            .q      (flag_q[g])
        );
    end

    cm_ref_counter #(.CW(CNT_W)) u_refcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .count (cnt_q)
    );

    cm_int_ctrl #(.DW(DW)) u_intc (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_irq_set  (wr_irq_set),
        .wr_irq_clr  (wr_irq_clr),
        .wr_fiq_set  (wr_fiq_set),
        .wr_fiq_clr  (wr_fiq_clr),
        .wr_soft_set (wr_soft_set),
        .wr_soft_clr (wr_soft_clr),
        .wdata       (wdata),
        .raw         (raw_lvl),
        .irq_en      (irq_en_q),
        .fiq_en      (fiq_en_q),
        .int_req     (int_req)
    );

    // Control word keeps only LED and remap; reset request is a registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            reset_req_q <= 1'b0;
        end else begin
            reset_req_q <= wr_ctrl && wdata[CTRL_RESET_BIT];
            if (wr_ctrl) ctrl_q <= (ctrl_q & ~CTRL_KEEP) | (wdata & CTRL_KEEP);
        end
    end

    // Plain read/write memory configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdram_q <= SDRAM_INIT;
            init_q  <= INIT_RST;
        end else begin
            if (wr_sdram) sdram_q <= wdata;
            if (wr_init)  init_q  <= wdata;
        end
    end

    assign led       = ctrl_q[CTRL_LED_BIT];
    assign remap     = ctrl_q[CTRL_REMAP_BIT];
    assign reset_req = reset_req_q;

    // read selection
    logic [DW-1:0] rd_val;
    logic          rd_bad;

    // Read mux: fixed registers, flag pairs, descriptor window, else error.
    always_comb begin
        rd_val = '0;
        rd_bad = 1'b0;
        case (addr)
            AW'(IX_ID):       rd_val = ID_WORD;
            AW'(IX_ZERO):     rd_val = '0;
            AW'(IX_OSC):      rd_val = osc_q;
            AW'(IX_CTRL):     rd_val = ctrl_q;
            AW'(IX_STAT):     rd_val = STAT_WORD;
            AW'(IX_LOCK):     rd_val = lock_rd;
            AW'(IX_AUX):      rd_val = aux_q;
            AW'(IX_SDRAM):    rd_val = sdram_q;
            AW'(IX_INIT):     rd_val = init_q;
            AW'(IX_CNT):      rd_val = DW'(cnt_q);
            AW'(IX_IRQ_STAT): rd_val = raw_lvl & irq_en_q;
            AW'(IX_RAW):      rd_val = raw_lvl;
            AW'(IX_IRQ_SET):  rd_val = irq_en_q;
            AW'(IX_SOFT_SET): rd_val = raw_lvl & DW'(1);
            AW'(IX_FIQ_STAT): rd_val = raw_lvl & fiq_en_q;
            AW'(IX_FIQ_RAW):  rd_val = raw_lvl;
            AW'(IX_FIQ_SET):  rd_val = fiq_en_q;
            default: begin
                if (int'(addr) >= IX_DESC_LO && int'(addr) < IX_DESC_MID)
                    rd_val = DW'(desc_byte(int'(addr)));
                else if (int'(addr) >= IX_DESC_MID && int'(addr) < IX_DESC_HI)
                    rd_val = '0;
                else
                    rd_bad = 1'b1;
            end
        endcase
        for (int g = 0; g < NUM_FLAG_REGS; g++) begin
            if (addr == AW'(IX_FLAG_BASE + 2*g)) begin
                rd_val = flag_q[g];
                rd_bad = 1'b0;
            end
        end
    end

    // Register read data and the error flag one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_err <= 1'b0;
        end else begin
            rd_err <= rd_en && rd_bad;
            if (rd_en) rdata <= rd_bad ? '0 : rd_val;
        end
    end

endmodule

// File: rtl/cm_sysctl_chk.sv
// Assertion checker for cm_sysctl, attached by bind. Observes bus ports,
// outputs and the state registers that the sub-blocks drive.
module cm_sysctl_chk
    import cm_sysctl_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = REG_W,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic             ctrl_rst_bit,
    input logic             ref_tick,
    input logic             rd_err,
    input logic             reset_req,
    input logic             remap,
    input logic             led,
    input logic             int_req,
    input logic [KEY_W-1:0] lock_q,
    input logic [DW-1:0]    osc_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [DW-1:0]    irq_en_q,
    input logic [DW-1:0]    fiq_en_q
);

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R5
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(wr_en && addr == AW'(IX_CTRL) && ctrl_rst_bit)); // R5
    AST_OSC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(IX_OSC) && lock_q != UNLOCK_KEY) |=> $stable(osc_q)); // R3
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == AW'(IX_CTRL)) |=> ($stable(remap) && $stable(led))); // R4
    AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> $past(rd_en)); // R11
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R7
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(cnt_q)); // R7
    AST_INT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (irq_en_q | fiq_en_q) != '0); // R8

endmodule

bind cm_sysctl cm_sysctl_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .ctrl_rst_bit (wdata[3]),
    .ref_tick     (ref_tick),
    .rd_err       (rd_err),
    .reset_req    (reset_req),
    .remap        (remap),
    .led          (led),
    .int_req      (int_req),
    .lock_q       (lock_q),
    .osc_q        (osc_q),
    .cnt_q        (cnt_q),
    .irq_en_q     (irq_en_q),
    .fiq_en_q     (fiq_en_q)
);

// File: tb/cm_sysctl_tb.sv
`timescale 1ns/1ps
module cm_sysctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ref_tick = 1'b0;
    logic [31:0] rdata;
    logic        rd_err, remap, led, reset_req, int_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cm_sysctl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .ref_tick  (ref_tick),
        .rdata     (rdata),
        .rd_err    (rd_err),
        .remap     (remap),
        .led       (led),
        .reset_req (reset_req),
        .int_req   (int_req)
    );

    // vector: {is_write, exp_err, index[7:0], wdata[31:0], expected[31:0]}
    localparam int NV = 60;
    localparam logic [73:0] VEC [NV] = '{
        {1'b0,1'b0,8'd0,  32'h0,        32'h411A3001}, // R1
        {1'b0,1'b0,8'd1,  32'h0,        32'h00000000}, // R1
        {1'b0,1'b0,8'd4,  32'h0,        32'h00100000}, // R1
        {1'b0,1'b0,8'd2,  32'h0,        32'h01000048}, // R9
        {1'b0,1'b0,8'd7,  32'h0,        32'h0007FEFF}, // R9
        {1'b0,1'b0,8'd8,  32'h0,        32'h0001112A}, // R9 size code 0x08
        {1'b0,1'b0,8'd9,  32'h0,        32'h00000112}, // R9
        {1'b0,1'b0,8'd5,  32'h0,        32'h00000000}, // R9
        {1'b0,1'b0,8'd3,  32'h0,        32'h00000000}, // R9
        {1'b1,1'b0,8'd2,  32'h12345678, 32'h0},        // R3 locked write
        {1'b0,1'b0,8'd2,  32'h0,        32'h01000048}, // R3
        {1'b1,1'b0,8'd5,  32'h1234A05F, 32'h0},        // R2 unlock
        {1'b0,1'b0,8'd5,  32'h0,        32'h0001A05F}, // R2
        {1'b1,1'b0,8'd2,  32'h12345678, 32'h0},        // R3
        {1'b0,1'b0,8'd2,  32'h0,        32'h12345678}, // R3
        {1'b1,1'b0,8'd7,  32'h0000CAFE, 32'h0},        // R3
        {1'b0,1'b0,8'd7,  32'h0,        32'h0000CAFE}, // R3
        {1'b1,1'b0,8'd5,  32'h0000BEEF, 32'h0},        // R2 relock
        {1'b0,1'b0,8'd5,  32'h0,        32'h0000BEEF}, // R2
        {1'b1,1'b0,8'd7,  32'h00000001, 32'h0},        // R3
        {1'b0,1'b0,8'd7,  32'h0,        32'h0000CAFE}, // R3
        {1'b1,1'b0,8'd12, 32'h000000F0, 32'h0},        // R6
        {1'b1,1'b0,8'd12, 32'h00000300, 32'h0},        // R6
        {1'b0,1'b0,8'd12, 32'h0,        32'h000003F0}, // R6
        {1'b1,1'b0,8'd13, 32'h000000A0, 32'h0},        // R6
        {1'b0,1'b0,8'd12, 32'h0,        32'h00000350}, // R6
        {1'b1,1'b0,8'd14, 32'h00000005, 32'h0},        // R6
        {1'b1,1'b0,8'd15, 32'h00000004, 32'h0},        // R6
        {1'b0,1'b0,8'd14, 32'h0,        32'h00000001}, // R6
        {1'b0,1'b0,8'd12, 32'h0,        32'h00000350}, // R6
        {1'b1,1'b0,8'd8,  32'h0000ABCD, 32'h0},        // R12
        {1'b0,1'b0,8'd8,  32'h0,        32'h0000ABCD}, // R12
        {1'b1,1'b0,8'd9,  32'h00000777, 32'h0},        // R12
        {1'b0,1'b0,8'd9,  32'h0,        32'h00000777}, // R12
        {1'b1,1'b0,8'd18, 32'h00000001, 32'h0},        // R8
        {1'b0,1'b0,8'd17, 32'h0,        32'h00000000}, // R8
        {1'b1,1'b0,8'd20, 32'hFFFFFFFF, 32'h0},        // R8
        {1'b0,1'b0,8'd17, 32'h0,        32'h00000001}, // R8
        {1'b0,1'b0,8'd25, 32'h0,        32'h00000001}, // R8
        {1'b0,1'b0,8'd16, 32'h0,        32'h00000001}, // R8
        {1'b0,1'b0,8'd24, 32'h0,        32'h00000000}, // R8
        {1'b0,1'b0,8'd20, 32'h0,        32'h00000001}, // R8
        {1'b1,1'b0,8'd26, 32'h00000003, 32'h0},        // R8
        {1'b0,1'b0,8'd26, 32'h0,        32'h00000003}, // R8
        {1'b0,1'b0,8'd24, 32'h0,        32'h00000001}, // R8
        {1'b1,1'b0,8'd19, 32'h00000001, 32'h0},        // R8
        {1'b0,1'b0,8'd16, 32'h0,        32'h00000000}, // R8
        {1'b0,1'b0,8'd18, 32'h0,        32'h00000000}, // R8
        {1'b1,1'b0,8'd21, 32'h00000001, 32'h0},        // R8
        {1'b0,1'b0,8'd17, 32'h0,        32'h00000000}, // R8
        {1'b0,1'b0,8'd73, 32'h0,        32'h00000053}, // R10 'S'
        {1'b0,1'b0,8'd74, 32'h0,        32'h00000044}, // R10 'D'
        {1'b0,1'b0,8'd83, 32'h0,        32'h0000004C}, // R10 'L'
        {1'b0,1'b0,8'd84, 32'h0,        32'h00000000}, // R10
        {1'b0,1'b0,8'd64, 32'h0,        32'h00000000}, // R10
        {1'b0,1'b0,8'd96, 32'h0,        32'h00000000}, // R10
        {1'b0,1'b1,8'd6,  32'h0,        32'h00000000}, // R11
        {1'b0,1'b1,8'd11, 32'h0,        32'h00000000}, // R11
        {1'b0,1'b1,8'd32, 32'h0,        32'h00000000}, // R11
        {1'b0,1'b1,8'd200,32'h0,        32'h00000000}  // R11
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        e = rd_err;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        logic        e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state at the outputs
        chk("R9", "rdata after reset", rdata, 32'h0);
        chk("R11", "rd_err after reset", {31'b0, rd_err}, 32'h0);
        chk("R4", "remap after reset", {31'b0, remap}, 32'h0);
        chk("R4", "led after reset", {31'b0, led}, 32'h0);
        chk("R5", "reset_req after reset", {31'b0, reset_req}, 32'h0);
        chk("R8", "int_req after reset", {31'b0, int_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][73]) begin
                do_write(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                do_read(VEC[i][71:64], d, e);
                chk("table", $sformatf("vector %0d index %0d data", i, VEC[i][71:64]), d, VEC[i][31:0]);
                chk("table", $sformatf("vector %0d index %0d err", i, VEC[i][71:64]), {31'b0, e}, {31'b0, VEC[i][72]});
            end
        end

        // R11: error flag lasts one cycle
        do_read(8'd6, d, e);
        @(negedge clk);
        chk("R11", "rd_err one cycle later", {31'b0, rd_err}, 32'h0);

        // R8: interrupt line through the FIQ path, then the IRQ path
        chk("R8", "int_req idle", {31'b0, int_req}, 32'h0);
        do_write(8'd20, 32'h1);
        chk("R8", "int_req via fiq enable", {31'b0, int_req}, 32'h1);
        do_write(8'd27, 32'h3);
        chk("R8", "int_req fiq cleared", {31'b0, int_req}, 32'h0);
        do_write(8'd18, 32'h1);
        chk("R8", "int_req via irq enable", {31'b0, int_req}, 32'h1);
        do_write(8'd21, 32'h1);
        chk("R8", "int_req soft dropped", {31'b0, int_req}, 32'h0);

        // R4 / R5: control word, remap, LED and reset pulse
        do_write(8'd3, 32'h0000000D);
        chk("R5", "reset_req pulse", {31'b0, reset_req}, 32'h1);
        chk("R4", "led set", {31'b0, led}, 32'h1);
        chk("R4", "remap set", {31'b0, remap}, 32'h1);
        @(negedge clk);
        chk("R5", "reset_req drops", {31'b0, reset_req}, 32'h0);
        do_read(8'd3, d, e);
        chk("R4", "ctrl readback bit3 zero", d, 32'h5);
        do_write(8'd3, 32'h00000002);
        chk("R4", "led cleared", {31'b0, led}, 32'h0);
        chk("R4", "remap cleared", {31'b0, remap}, 32'h0);
        chk("R5", "no pulse without bit3", {31'b0, reset_req}, 32'h0);

        // R7: reference counter
        do_read(8'd10, d, e);
        chk("R7", "counter idle", d, 32'h0);
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (7) @(negedge clk);
        ref_tick = 1'b0;
        do_read(8'd10, d, e);
        chk("R7", "counter after 7 ticks", d, 32'h7);
        do_write(8'd10, 32'hFFFF0000);
        do_read(8'd10, d, e);
        chk("R7", "counter write ignored", d, 32'h7);

        // R11: writes to unimplemented indices change nothing
        do_write(8'd6, 32'hFFFFFFFF);
        do_write(8'd32, 32'hFFFFFFFF);
        do_write(8'd64, 32'hFFFFFFFF);
        do_read(8'd12, d, e);
        chk("R11", "flags after stray writes", d, 32'h350);
        do_read(8'd2, d, e);
        chk("R11", "osc after stray writes", d, 32'h12345678);
        do_read(8'd64, d, e);
        chk("R11", "descriptor after stray write", d, 32'h0);

        // R9 / R7: mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(8'd10, d, e);
        chk("R7", "counter cleared by reset", d, 32'h0);
        do_read(8'd2, d, e);
        chk("R9", "osc reset value", d, 32'h01000048);
        do_read(8'd12, d, e);
        chk("R9", "flags reset", d, 32'h0);
        do_read(8'd5, d, e);
        chk("R9", "lock reset", d, 32'h0);
        do_read(8'd8, d, e);
        chk("R9", "sdram reset", d, 32'h0001112A);

        done = 1'b1;
        summary();
    end

endmodule